// File: doc/BRIEF.md
# Debug Register Ownership Write Filter

This block holds a bank of debug control and status registers that two agents share: an external hardware debugger and software on the core. A resource-grant register carries one bit per debug feature saying whether software owns it. Every software write to the bank passes through a per-bit write mask, so only fields that software owns change. The debugger has its own write port and may change any field. Event pulses from the core always set their status bits, whoever owns them. Reads from either side return the true register contents.

Ownership applies only while the external-debug enable bit in the main control register is set. With that bit clear, software writes every control and status register freely. With it set and the software-mode grant clear, software writes to the control and status registers are all dropped. With both set, software may write the software-mode field, plus each field whose grant bit is set.

A three-state access-mode machine follows the two bits that decide the regime. MODE_OPEN means external debug is off. MODE_LOCKED means external debug is on with no software-mode grant. MODE_SHARED means external debug is on and the grant is set. The transitions are ARM (OPEN to LOCKED), ARM_GRANTED (OPEN to SHARED), GRANT (LOCKED to SHARED), REVOKE (SHARED to LOCKED) and DISARM (LOCKED or SHARED to OPEN). The next state is computed from the register values being written, so the mode always matches the registers.

Top module: `dbg_own_filter`

Register selects: 0 is the main control register CTRL0. Selects 1 to 4 are CTRL1 to CTRL4. Select 5 is STATUS. Select 6 is the grant register GRANT. Select 7 reads zero and ignores writes.

CTRL0 fields:

| Field | Bit(s) | Meaning |
|---|---|---|
| EXT | 31 | external-debug enable |
| SWM | 30 | software debug mode |
| RSTF | 29:28 | reset field |
| Event enables | 27 to 23 | instruction-complete (27), branch-taken (26), interrupt-taken (25), trap (24), address-compare-1 (23) |

STATUS fields:

| Field | Bit | Meaning |
|---|---|---|
| UNC | 31 | unconditional event |
| Event status | 27 to 23 | same event order as the CTRL0 enables |

GRANT fields:

| Bit | Grants software access to |
|---|---|
| 0 | reserved |
| 1 | software mode |
| 2 | reset field |
| 3 | unconditional event |
| 4 | instruction-complete |
| 5 | branch-taken |
| 6 | interrupt-taken |
| 7 | trap |
| 8 | address-compare-1 |

Event input `evt_set` has one bit per event. Bit 0 is the unconditional event. Bits 1 to 5 are the five paired events in the order above.

## Requirements
- R1: While rst_n is low, every register clears to zero, and the block comes out of reset in MODE_OPEN.
- R2: With CTRL0 bit 31 clear, a software write to CTRL0..CTRL4 or STATUS replaces the whole register on the next clock edge.
- R3: With CTRL0 bit 31 set and GRANT bit 1 clear, software writes to CTRL0..CTRL4 and STATUS leave them unchanged, whatever the other GRANT bits hold.
- R4: With CTRL0 bit 31 and GRANT bit 1 set, a software write updates CTRL0 bit 30 and the fields whose grants are set. All other bits in the same write keep their value, and CTRL1..CTRL4 are not written.
- R5: In MODE_SHARED, software changes CTRL0 bits 29:28 only when GRANT bit 2 is set.
- R6: In MODE_SHARED, GRANT bit 3 lets software write only STATUS bit 31. No CTRL0 bit depends on it.
- R7: In MODE_SHARED, GRANT bit 4+k (k = 0..4) lets software write both CTRL0 bit 27-k and STATUS bit 27-k.
- R8: GRANT bit 0 and bits 31:9 always read zero, and software can never write GRANT.
- R9: rd_data returns the true contents of the register chosen by rd_sel in every mode, and zero for select 7.
- R10: A set bit in evt_set sets its STATUS bit on the next edge in every mode, even against a same-cycle software or debugger write that clears it.
- R11: When the debugger port and software write the same register in one cycle, the register takes the debugger data.
- R12: Debugger writes update every writable bit of any register in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sw_we | input | 1 | software write strobe |
| sw_sel | input | 3 | software register select |
| sw_wdata | input | 32 | software write data |
| hw_we | input | 1 | debugger write strobe |
| hw_sel | input | 3 | debugger register select |
| hw_wdata | input | 32 | debugger write data |
| evt_set | input | 6 | event pulses that set status bits |
| rd_sel | input | 3 | read select |
| rd_data | output | 32 | contents of the selected register |
| ctrl0_q | output | 32 | current CTRL0 |
| status_q | output | 32 | current STATUS |
| grant_q | output | 32 | current GRANT |

## Verification
The hardest case to reach from the ports is a partly granted MODE_SHARED. In that case a single software write must split per bit, sometimes in the same cycle as an event pulse or a debugger write. Random stimulus biases debugger writes towards CTRL0 with bit 31 mostly set, and towards random GRANT values. This keeps the block in MODE_SHARED with varied grant masks most of the time, while software writes and events arrive at random. Directed sequences first set exact grant patterns, so that each single-grant split and each collision gets a known literal result.

// File: rtl/dbg_own_pkg.sv
package dbg_own_pkg;
    localparam int DW       = 32;
    localparam int SELW     = 3;
    localparam int NREG     = 7;
    localparam int NPAIR    = 5;
    localparam int NEV      = NPAIR + 1;

    localparam int SEL_C0   = 0;
    localparam int SEL_ST   = 5;
    localparam int SEL_GR   = 6;

    localparam int C0_EXT   = 31;
    localparam int C0_SWM   = 30;
    localparam int C0_RSTH  = 29;
    localparam int C0_RSTL  = 28;
    localparam int PAIR_TOP = 27;
    localparam int ST_UNC   = 31;

    localparam int G_SWM    = 1;
    localparam int G_RST    = 2;
    localparam int G_UNC    = 3;
    localparam int G_PAIR0  = 4;
    localparam int G_TOP    = G_PAIR0 + NPAIR - 1;

    localparam logic [DW-1:0] GRANT_VALID = DW'(((1 << (G_TOP + 1)) - 1) & ~1);

    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_LOCKED = 2'd1,
        MODE_SHARED = 2'd2
    } mode_e;
endpackage

// File: rtl/dbg_own_mode_fsm.sv
module dbg_own_mode_fsm
    import dbg_own_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  nxt_ext,
    input  logic  nxt_grant,
    output mode_e mode
);
    mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OPEN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OPEN: begin
                if (nxt_ext) mode_d = nxt_grant ? MODE_SHARED : MODE_LOCKED; // ARM / ARM_GRANTED
            end
            MODE_LOCKED: begin
                if (!nxt_ext)      mode_d = MODE_OPEN;                    // DISARM
                else if (nxt_grant) mode_d = MODE_SHARED;                 // GRANT
            end
            MODE_SHARED: begin
                if (!nxt_ext)       mode_d = MODE_OPEN;                   // DISARM
                else if (!nxt_grant) mode_d = MODE_LOCKED;                // REVOKE
            end
            default: mode_d = MODE_OPEN;
        endcase
    end

    assign mode = mode_q;
endmodule

// File: rtl/dbg_own_mask.sv
module dbg_own_mask
    import dbg_own_pkg::*;
(
    input  mode_e           mode,
    input  logic [G_TOP:1]  grant,
    output logic [DW-1:0]   mask_c0,
    output logic [DW-1:0]   mask_cx,
    output logic [DW-1:0]   mask_st
);
    always_comb begin
        mask_c0 = '0;
        mask_cx = '0;
        mask_st = '0;
        unique case (mode)
            MODE_OPEN: begin
                mask_c0 = '1;
                mask_cx = '1;
                mask_st = '1;
            end
            MODE_LOCKED: begin
                mask_c0 = '0;
            end
            MODE_SHARED: begin
                mask_c0[C0_SWM] = 1'b1;
                if (grant[G_RST]) mask_c0[C0_RSTH:C0_RSTL] = 2'b11;
                if (grant[G_UNC]) mask_st[ST_UNC] = 1'b1;
                for (int k = 0; k < NPAIR; k++) begin
                    if (grant[G_PAIR0 + k]) begin
                        mask_c0[PAIR_TOP - k] = 1'b1;
                        mask_st[PAIR_TOP - k] = 1'b1;
                    end
                end
            end
            default: mask_c0 = '0;
        endcase
    end
endmodule

// File: rtl/dbg_own_regs.sv
module dbg_own_regs
    import dbg_own_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [SELW-1:0] sw_sel,
    input  logic [DW-1:0]   sw_wdata,
    input  logic            hw_we,
    input  logic [SELW-1:0] hw_sel,
    input  logic [DW-1:0]   hw_wdata,
    input  logic [NEV-1:0]  evt_set,
    input  logic [DW-1:0]   mask_c0,
    input  logic [DW-1:0]   mask_cx,
    input  logic [DW-1:0]   mask_st,
    output logic [DW-1:0]   regs_q   [NREG],
    output logic            nxt_ext,
    output logic            nxt_grant
);
    logic [DW-1:0] ev_bits;
    logic [DW-1:0] nxt_all [NREG];

    always_comb begin
        ev_bits = '0;
        ev_bits[ST_UNC] = evt_set[0];
        for (int k = 0; k < NPAIR; k++) ev_bits[PAIR_TOP - k] = evt_set[k + 1];
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DW-1:0] wmask;
        logic [DW-1:0] nxt;
        logic [DW-1:0] q;

        if (r == SEL_C0)      begin : g_m0 assign wmask = mask_c0; end
        else if (r == SEL_ST) begin : g_ms assign wmask = mask_st; end
        else if (r == SEL_GR) begin : g_mg assign wmask = '0;      end
        else                  begin : g_mx assign wmask = mask_cx; end

        always_comb begin
            nxt = q;
            if (hw_we && hw_sel == SELW'(r))
                nxt = hw_wdata;
            else if (sw_we && sw_sel == SELW'(r))
                nxt = (q & ~wmask) | (sw_wdata & wmask);
            if (r == SEL_ST) nxt = nxt | ev_bits;
            if (r == SEL_GR) nxt = nxt & GRANT_VALID;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign regs_q[r]  = q;
        assign nxt_all[r] = nxt;
    end

    assign nxt_ext   = nxt_all[SEL_C0][C0_EXT];
    assign nxt_grant = nxt_all[SEL_GR][G_SWM];
endmodule

// File: rtl/dbg_own_filter.sv
module dbg_own_filter
    import dbg_own_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [SELW-1:0] sw_sel,
    input  logic [DW-1:0]   sw_wdata,
    input  logic            hw_we,
    input  logic [SELW-1:0] hw_sel,
    input  logic [DW-1:0]   hw_wdata,
    input  logic [NEV-1:0]  evt_set,
    input  logic [SELW-1:0] rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   ctrl0_q,
    output logic [DW-1:0]   status_q,
    output logic [DW-1:0]   grant_q
);
    mode_e         mode;
    logic [DW-1:0] mask_c0, mask_cx, mask_st;
    logic [DW-1:0] regs [NREG];
    logic          nxt_ext, nxt_grant;

    dbg_own_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_ext   (nxt_ext),
        .nxt_grant (nxt_grant),
        .mode      (mode)
    );

    dbg_own_mask u_mask (
        .mode    (mode),
        .grant   (regs[SEL_GR][G_TOP:1]),
        .mask_c0 (mask_c0),
        .mask_cx (mask_cx),
        .mask_st (mask_st)
    );

    dbg_own_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .sw_sel    (sw_sel),
        .sw_wdata  (sw_wdata),
        .hw_we     (hw_we),
        .hw_sel    (hw_sel),
        .hw_wdata  (hw_wdata),
        .evt_set   (evt_set),
        .mask_c0   (mask_c0),
        .mask_cx   (mask_cx),
        .mask_st   (mask_st),
        .regs_q    (regs),
        .nxt_ext   (nxt_ext),
        .nxt_grant (nxt_grant)
    );

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREG; r++)
            if (rd_sel == SELW'(r)) rd_data = regs[r];
    end

    assign ctrl0_q  = regs[SEL_C0];
    assign status_q = regs[SEL_ST];
    assign grant_q  = regs[SEL_GR];
endmodule

// File: rtl/dbg_own_filter_chk.sv
module dbg_own_filter_chk
    import dbg_own_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            sw_we,
    input logic [SELW-1:0] sw_sel,
    input logic [DW-1:0]   sw_wdata,
    input logic            hw_we,
    input logic [SELW-1:0] hw_sel,
    input logic [DW-1:0]   hw_wdata,
    input logic [NEV-1:0]  evt_set,
    input logic [DW-1:0]   ctrl0_q,
    input logic [DW-1:0]   status_q,
    input logic [DW-1:0]   grant_q
);
    function automatic logic [DW-1:0] ev_map(input logic [NEV-1:0] e);
        logic [DW-1:0] m;
        m = '0;
        m[ST_UNC] = e[0];
        for (int k = 0; k < NPAIR; k++) m[PAIR_TOP - k] = e[k + 1];
        return m;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl0_q == '0 && status_q == '0 && grant_q == '0));

    assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_sel == SELW'(SEL_C0) && !ctrl0_q[C0_EXT]
         && !(hw_we && hw_sel == SELW'(SEL_C0)))
        |=> ctrl0_q == $past(sw_wdata));

    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_sel == SELW'(SEL_ST) && ctrl0_q[C0_EXT] && !grant_q[G_SWM]
         && !hw_we && evt_set == '0)
        |=> $stable(status_q));

    assert_grant_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q & ~GRANT_VALID) == '0);

    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((status_q & $past(ev_map(evt_set))) == $past(ev_map(evt_set))));

    assert_hw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && hw_sel == SELW'(SEL_C0)) |=> ctrl0_q == $past(hw_wdata));
endmodule

bind dbg_own_filter dbg_own_filter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_we),
    .sw_sel   (sw_sel),
    .sw_wdata (sw_wdata),
    .hw_we    (hw_we),
    .hw_sel   (hw_sel),
    .hw_wdata (hw_wdata),
    .evt_set  (evt_set),
    .ctrl0_q  (ctrl0_q),
    .status_q (status_q),
    .grant_q  (grant_q)
);

// File: tb/test_dbg_own_filter.sv
`timescale 1ns/1ps
module test_dbg_own_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_we, hw_we;
    logic [2:0]  sw_sel, hw_sel, rd_sel;
    logic [31:0] sw_wdata, hw_wdata;
    logic [5:0]  evt_set;
    logic [31:0] rd_data, ctrl0_q, status_q, grant_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] m [7];

    always #2.5 clk = ~clk;

    dbg_own_filter i_dbg_own_filter (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .hw_we(hw_we), .hw_sel(hw_sel), .hw_wdata(hw_wdata), .evt_set(evt_set),
        .rd_sel(rd_sel), .rd_data(rd_data), .ctrl0_q(ctrl0_q), .status_q(status_q),
        .grant_q(grant_q)
    );

    function automatic logic [31:0] sw_mask(int sel, logic [31:0] c0, logic [31:0] g);
        logic [31:0] k;
        k = 32'h0;
        if (sel > 5) return 32'h0;
        if (!c0[31]) return 32'hFFFF_FFFF;
        if (!g[1]) return 32'h0;
        if (sel == 0) begin
            k[30] = 1'b1;
            if (g[2]) k[29:28] = 2'b11;
            for (int j = 0; j < 5; j++) if (g[4+j]) k[27-j] = 1'b1;
        end else if (sel == 5) begin
            if (g[3]) k[31] = 1'b1;
            for (int j = 0; j < 5; j++) if (g[4+j]) k[27-j] = 1'b1;
        end
        return k;
    endfunction

    function automatic logic [31:0] ev_bits(logic [5:0] e);
        logic [31:0] b;
        b = 32'h0;
        b[31] = e[0];
        for (int j = 0; j < 5; j++) b[27-j] = e[j+1];
        return b;
    endfunction

    function automatic string mode_tag();
        if (!m[0][31]) return "R2";
        if (!m[6][1])  return "R3";
        return "R4";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int s = 0; s < 7; s++) begin
            rd_sel = 3'(s);
            #0.2;
            chk(tag, rd_data, m[s]);
        end
    endtask

    task automatic rd_lit(string tag, int sel, logic [31:0] exp);
        rd_sel = 3'(sel);
        #0.2;
        chk(tag, rd_data, exp);
    endtask

    task automatic step(logic swe, logic [2:0] ss, logic [31:0] sd,
                        logic hwe, logic [2:0] hs, logic [31:0] hd, logic [5:0] ev);
        logic [31:0] nx [7];
        sw_we = swe; sw_sel = ss; sw_wdata = sd;
        hw_we = hwe; hw_sel = hs; hw_wdata = hd; evt_set = ev;
        for (int r = 0; r < 7; r++) begin
            logic [31:0] k;
            k = sw_mask(r, m[0], m[6]);
            nx[r] = m[r];
            if (hwe && hs == 3'(r)) nx[r] = hd;
            else if (swe && ss == 3'(r)) nx[r] = (m[r] & ~k) | (sd & k);
            if (r == 5) nx[r] = nx[r] | ev_bits(ev);
            if (r == 6) nx[r] = nx[r] & 32'h0000_01FE;
        end
        @(posedge clk);
        for (int r = 0; r < 7; r++) m[r] = nx[r];
        @(negedge clk);
        sw_we = 1'b0; hw_we = 1'b0; evt_set = 6'h0;
    endtask

    task automatic hw(int sel, logic [31:0] d);
        step(1'b0, 3'd0, 32'h0, 1'b1, 3'(sel), d, 6'h0);
    endtask

    task automatic sw(int sel, logic [31:0] d);
        step(1'b1, 3'(sel), d, 1'b0, 3'd0, 32'h0, 6'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; sw_we = 0; hw_we = 0; sw_sel = 0; hw_sel = 0;
        sw_wdata = 0; hw_wdata = 0; evt_set = 0; rd_sel = 0;
        for (int r = 0; r < 7; r++) m[r] = 32'h0;
        // R1: reset after debugger junk
        @(negedge clk);
        hw_we = 1'b1; hw_sel = 3'd0; hw_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        hw_we = 1'b0;
        rst_n = 1'b1;
        chk("R1 ctrl0", ctrl0_q, 32'h0);
        chk("R1 status", status_q, 32'h0);
        chk("R1 grant", grant_q, 32'h0);
        compare_all("R1");

        // R2: open mode, full software write
        sw(1, 32'hA5A5_5A5A);
        rd_lit("R2 ctrl1", 1, 32'hA5A5_5A5A);
        sw(5, 32'h1234_0000);
        rd_lit("R2 status", 5, 32'h1234_0000);
        hw(5, 32'h0);

        // R12 / R3: locked mode
        hw(0, 32'h8000_0000);
        hw(6, 32'hFFFF_FFFC);
        rd_lit("R12 grant", 6, 32'h0000_01FC);
        sw(5, 32'hFFFF_FFFF);
        rd_lit("R3 status", 5, 32'h0);
        sw(0, 32'h0);
        rd_lit("R3 ctrl0", 0, 32'h8000_0000);
        sw(2, 32'hFFFF_FFFF);
        rd_lit("R3 ctrl2", 2, 32'h0);

        // R4: shared, all grants
        hw(6, 32'h0000_01FE);
        sw(0, 32'hFFFF_FFFF);
        rd_lit("R4 ctrl0", 0, 32'hFF80_0000);
        sw(0, 32'h0);
        rd_lit("R4 ctrl0 ext kept", 0, 32'h8000_0000);
        sw(3, 32'hFFFF_FFFF);
        rd_lit("R4 ctrl3", 3, 32'h0);

        // R5: reset field grant clear
        hw(6, 32'h0000_01FA);
        sw(0, 32'hFFFF_FFFF);
        rd_lit("R5 ctrl0", 0, 32'hCF80_0000);

        // R6: only unconditional grant
        hw(0, 32'h8000_0000);
        hw(6, 32'h0000_000A);
        sw(5, 32'hFFFF_FFFF);
        rd_lit("R6 status", 5, 32'h8000_0000);
        sw(0, 32'hFFFF_FFFF);
        rd_lit("R6 ctrl0", 0, 32'hC000_0000);

        // R7: branch-taken pair only
        hw(0, 32'h8000_0000);
        hw(5, 32'h0);
        hw(6, 32'h0000_0022);
        sw(5, 32'hFFFF_FFFF);
        rd_lit("R7 status", 5, 32'h0400_0000);
        sw(0, 32'hFFFF_FFFF);
        rd_lit("R7 ctrl0", 0, 32'hC400_0000);

        // R8: grant reserved bits, software cannot write grant
        hw(6, 32'hFFFF_FFFF);
        rd_lit("R8 grant", 6, 32'h0000_01FE);
        sw(6, 32'h0);
        chk("R8 grant sw", grant_q, 32'h0000_01FE);

        // R9: true read-back in locked mode, select 7
        hw(6, 32'h0);
        hw(0, 32'h8000_1234);
        rd_lit("R9 ctrl0", 0, 32'h8000_1234);
        rd_lit("R9 sel7", 7, 32'h0);

        // R10: events beat clears
        hw(6, 32'h0000_01FE);
        hw(5, 32'h0);
        step(1'b1, 3'd5, 32'h0, 1'b0, 3'd0, 32'h0, 6'b000010);
        rd_lit("R10 status", 5, 32'h0800_0000);
        step(1'b0, 3'd0, 32'h0, 1'b1, 3'd5, 32'h0, 6'b000001);
        rd_lit("R10 status hw", 5, 32'h8000_0000);

        // R11: collision, debugger wins
        hw(0, 32'h0);
        step(1'b1, 3'd1, 32'h1111_1111, 1'b1, 3'd1, 32'h2222_2222, 6'h0);
        rd_lit("R11 ctrl1", 1, 32'h2222_2222);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic swe, hwe;
            logic [2:0] ss, hs;
            logic [31:0] sd, hd;
            logic [5:0] ev;
            string tag;
            swe = ($urandom % 4) != 0;
            ss  = 3'($urandom % 8);
            sd  = $urandom;
            hwe = ($urandom % 4) == 0;
            hs  = (($urandom % 2) == 0) ? 3'(($urandom % 2) * 6) : 3'($urandom % 7);
            hd  = $urandom;
            if (hs == 3'd0) hd[31] = ($urandom % 4) != 0;
            if (hs == 3'd6) hd[1]  = ($urandom % 4) != 0;
            ev  = (($urandom % 8) == 0) ? 6'($urandom) : 6'h0;
            tag = (hwe && swe && hs == ss) ? "R11" : (ev != 0) ? "R10" : mode_tag();
            step(swe, ss, sd, hwe, hs, hd, ev);
            compare_all(tag);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule